// File: doc/BRIEF.md
# Fractional-Rate Realtime Master Counter

This block keeps a free-running wide count that advances at a steady nominal rate of 6.144 MHz. That rate is derived from a faster system clock by a programmable rational ratio. On every system-clock cycle a fractional accumulator adds a numerator. When the sum reaches the denominator, the accumulator drops by the denominator and the count moves up by one. The ratio field is 12 bits wide and lives in two 32-bit software registers. Typical settings are 4/25 at 38.4 MHz, 8/25 at 19.2 MHz, 64/125 at 12 MHz and 768/1625 at 13 MHz. The ratio 75/244 is used when the slow reference comes from the system clock divided by 610.

A slow reference tick, already synchronous to the system clock and one cycle wide, can re-align the fine count. Each accepted tick adds 187 or 188 to a coarse reference, taking the two values in turn. The fine count is then loaded from that reference, which removes drift that built up between ticks. Software reads the count as two halves. A read of the low half freezes the high half so that the two halves form a coherent pair.

Top module: `rt_master_counter`

## Requirements
- R1: A synchronous active-high reset clears the count, the accumulator, the coarse reference and the step phase. It also sets the numerator word to 4 and the denominator word to 25.
- R2: With a nonzero denominator and a numerator no larger than it, N cycles after the accumulator was cleared the count has risen by floor(N*num/den). It never rises by more than one per cycle.
- R3: The numerator word is at offset 0x10 and the denominator word at offset 0x14. Only bits 11:0 set the ratio. Bits 31:12 are stored as written and read back unchanged. The count's low half is at 0x00 and its high half at 0x04. Any other offset reads 0. Read data appears in the cycle after the read strobe.
- R4: A write to either ratio word clears the accumulator, and no step happens in that cycle. The count keeps its value.
- R5: While the denominator field is 0, the count holds.
- R6: A read of the low half captures the high half at the same instant. A later read of 0x04 returns that captured value, even if the count has since crossed a half boundary.
- R7: A coarse tick with `align_en` high adds the next step to the coarse reference, loads the count from the result and clears the accumulator. The steps are 187 then 188, alternating, starting with 187 after reset. The load takes priority over a fractional step.
- R8: A coarse tick with `align_en` low changes neither the count, the reference nor the step phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the accessed register |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Registered read data |
| coarse_tick | input | 1 | One-cycle slow reference pulse, already synchronous |
| align_en | input | 1 | Accepts coarse ticks when high |

## Verification
The bench sweeps the rate over a set of ratios: the nominal settings, 75/244, 192/625, 3/7 and the edge ratio 1/1. Each ratio is tried with windows shorter than one denominator, just under one denominator and over several denominators, so that errors in the floor, a missed carry and a wrong residue each produce a different count. A rewrite of an unchanged ratio in mid-run separates an accumulator that is cleared from one that is kept. A chain of three accepted ticks, one refused tick and one tick that collides with a running step separates the right alternation from a phase that moves on a refused tick, and a load from a step. A 1/1 run read just below a half boundary separates a captured high half from a live one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFS_CNT_LO = 'h00;
  localparam int unsigned OFS_CNT_HI = 'h04;
  localparam int unsigned OFS_NUM    = 'h10;
  localparam int unsigned OFS_DEN    = 'h14;
  localparam int unsigned STEP_EVEN  = 187;
  localparam int unsigned STEP_ODD   = 188;
  localparam int unsigned DEF_NUM    = 4;
  localparam int unsigned DEF_DEN    = 25;
endpackage

// File: rtl/rtc_ratio_regs.sv
module rtc_ratio_regs #(
  parameter int REG_W   = 32,
  parameter int RATIO_W = 12,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   num_word,
  output logic [REG_W-1:0]   den_word,
  output logic [RATIO_W-1:0] num,
  output logic [RATIO_W-1:0] den,
  output logic               ratio_wr
);
  localparam logic [ADDR_W-1:0] A_NUM = ADDR_W'(rtc_pkg::OFS_NUM);
  localparam logic [ADDR_W-1:0] A_DEN = ADDR_W'(rtc_pkg::OFS_DEN);

  logic hit_num, hit_den;

  assign hit_num  = wr_en && (addr == A_NUM);
  assign hit_den  = wr_en && (addr == A_DEN);
  assign ratio_wr = hit_num || hit_den;
  assign num      = num_word[RATIO_W-1:0];
  assign den      = den_word[RATIO_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      num_word <= REG_W'(rtc_pkg::DEF_NUM);
      den_word <= REG_W'(rtc_pkg::DEF_DEN);
    end else begin
      if (hit_num) num_word <= wdata;
      if (hit_den) den_word <= wdata;
    end
  end

  // R3: the ratio words change only through a write strobe
  p_words_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(num_word) && $stable(den_word)));
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
  parameter int RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [RATIO_W-1:0] num,
  input  logic [RATIO_W-1:0] den,
  output logic               step
);
  localparam int ACC_W = RATIO_W + 1;

  logic [ACC_W-1:0] acc_q, sum;
  logic             reach;

  assign sum   = acc_q + ACC_W'(num);
  assign reach = (den != '0) && (sum >= ACC_W'(den));
  assign step  = reach && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr || den == '0) acc_q <= '0;
    else if (reach)              acc_q <= sum - ACC_W'(den);
    else                         acc_q <= sum;
  end

  // R2: the residue stays below the denominator while the ratio is legal
  p_acc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && den != '0 && num <= den && acc_q < ACC_W'(den))
      |=> (acc_q < ACC_W'($past(den))));
endmodule

// File: rtl/rtc_coarse_align.sv
module rtc_coarse_align #(
  parameter int          CNT_W   = 64,
  parameter int unsigned STEP_LO = 187,
  parameter int unsigned STEP_HI = 188
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] ref_q
);
  logic             phase_q;
  logic [CNT_W-1:0] inc;

  assign inc      = phase_q ? CNT_W'(STEP_HI) : CNT_W'(STEP_LO);
  assign load     = tick && en;
  assign load_val = ref_q + inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      phase_q <= 1'b0;
    end else if (load) begin
      ref_q   <= load_val;
      phase_q <= ~phase_q;
    end
  end

  // R7: each accepted tick moves the reference by one of the two steps
  p_ref_step_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> ((ref_q - $past(ref_q)) == CNT_W'(STEP_LO) ||
              (ref_q - $past(ref_q)) == CNT_W'(STEP_HI)));
  // R8: without an accepted tick the reference holds
  p_ref_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ref_q));
endmodule

// File: rtl/rt_master_counter.sv
module rt_master_counter #(
  parameter int          CNT_W   = 64,
  parameter int          HALF_W  = 32,
  parameter int          REG_W   = 32,
  parameter int          RATIO_W = 12,
  parameter int          ADDR_W  = 8,
  parameter int unsigned STEP_LO = rtc_pkg::STEP_EVEN,
  parameter int unsigned STEP_HI = rtc_pkg::STEP_ODD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              coarse_tick,
  input  logic              align_en
);
  localparam int HI_W = CNT_W - HALF_W;
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(rtc_pkg::OFS_CNT_LO);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(rtc_pkg::OFS_CNT_HI);
  localparam logic [ADDR_W-1:0] A_NUM = ADDR_W'(rtc_pkg::OFS_NUM);
  localparam logic [ADDR_W-1:0] A_DEN = ADDR_W'(rtc_pkg::OFS_DEN);

  logic [REG_W-1:0]   num_word, den_word, rdata_q;
  logic [RATIO_W-1:0] num, den;
  logic               ratio_wr, step, load;
  logic [CNT_W-1:0]   load_val, ref_q, count_q;
  logic [HI_W-1:0]    hi_latch_q;

  rtc_ratio_regs #(.REG_W(REG_W), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .num_word(num_word), .den_word(den_word), .num(num), .den(den),
    .ratio_wr(ratio_wr)
  );

  rtc_frac_accum #(.RATIO_W(RATIO_W)) u_accum (
    .clk(clk), .rst(rst), .clr(ratio_wr || load), .num(num), .den(den),
    .step(step)
  );

  rtc_coarse_align #(.CNT_W(CNT_W), .STEP_LO(STEP_LO), .STEP_HI(STEP_HI)) u_align (
    .clk(clk), .rst(rst), .tick(coarse_tick), .en(align_en),
    .load(load), .load_val(load_val), .ref_q(ref_q)
  );

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (load) count_q <= load_val;
    else if (step) count_q <= count_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      hi_latch_q <= '0;
    end else if (rd_en) begin
      if (addr == A_LO) begin
        rdata_q    <= REG_W'(count_q[HALF_W-1:0]);
        hi_latch_q <= count_q[CNT_W-1:HALF_W];
      end else if (addr == A_HI) begin
        rdata_q <= REG_W'(hi_latch_q);
      end else if (addr == A_NUM) begin
        rdata_q <= num_word;
      end else if (addr == A_DEN) begin
        rdata_q <= den_word;
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign rdata = rdata_q;

  // R2: the count moves by at most one between loads
  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));
  // R5: a zero denominator freezes the count
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (den == '0 && !load) |=> $stable(count_q));
  // R4: a ratio write leaves the count where it was
  p_wr_keeps_count_r4: assert property (@(posedge clk) disable iff (rst)
    (ratio_wr && !load) |=> $stable(count_q));
  // R7: after an accepted tick the count equals the coarse reference
  p_load_match_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == ref_q));
endmodule

// File: tb/tb_rt_master_counter.sv
module tb_rt_master_counter;
  localparam int CW = 20;
  localparam int HW = 10;
  localparam longint CMASK = (longint'(1) << CW) - 1;
  localparam longint LMASK = (longint'(1) << HW) - 1;

  logic        clk = 1'b0;
  logic        rst, wr_en, rd_en, coarse_tick, align_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rt_master_counter #(.CNT_W(CW), .HALF_W(HW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .coarse_tick(coarse_tick), .align_en(align_en)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output longint v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = longint'(rdata);
  endtask

  task automatic rd_full(output longint v);
    longint lo, hi;
    rd(8'h00, lo);
    rd(8'h04, hi);
    v = (hi << HW) | lo;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic en);
    @(negedge clk); coarse_tick = 1'b1; align_en = en;
    @(negedge clk); coarse_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint v, c0, c1, lo, hi, m, exp;
    int nums [8] = '{4, 8, 64, 768, 75, 192, 1, 3};
    int dens [8] = '{25, 25, 125, 1625, 244, 625, 1, 7};
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    coarse_tick = 0; align_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 and R2: default 4/25 after reset, 100 update edges
    idle(99);
    rd(8'h00, v);  chk("R1 default rate low", v, 16);
    rd(8'h04, v);  chk("R1 high half after reset", v, 0);
    rd(8'h10, v);  chk("R1 default numerator", v, 4);
    rd(8'h14, v);  chk("R1 default denominator", v, 25);
    rd(8'h08, v);  chk("R3 unmapped offset", v, 0);

    // R7/R8: coarse alignment with the count frozen
    wr(8'h14, 32'd0);
    tick(1'b1); rd(8'h00, v); chk("R7 first tick 187", v, 187);
    tick(1'b1); rd(8'h00, v); chk("R7 second tick 375", v, 375);
    tick(1'b1); rd(8'h00, v); chk("R7 third tick 562", v, 562);
    tick(1'b0); rd(8'h00, v); chk("R8 refused tick", v, 562);
    wr(8'h10, 32'd1); wr(8'h14, 32'd1);
    tick(1'b1); rd(8'h00, v); chk("R7 tick over running step", v, 751);

    // R5: zero denominator holds the count
    wr(8'h14, 32'd0);
    rd_full(c0); idle(50); rd_full(c1);
    chk("R5 frozen count", c1, c0);

    // R4: rewriting the numerator clears the residue, keeps the count
    wr(8'h10, 32'd4); wr(8'h14, 32'd25); wr(8'h10, 32'd4);
    idle(5);
    rd(8'h00, v); chk("R4 residue cleared count kept", v, c0 & LMASK);

    // R2/R3 sweep over ratios and window lengths
    foreach (nums[i]) begin
      for (int k = 0; k < 3; k++) begin
        m = (k == 0) ? 0 : (k == 1) ? ((dens[i] >= 2) ? dens[i] - 2 : 3) : 2 * dens[i] + 5;
        wr(8'h14, 32'd0);
        rd_full(c0);
        wr(8'h10, {20'hA5C3E, 12'(nums[i])});
        wr(8'h14, {20'h5A3C1, 12'(dens[i])});
        idle(int'(m));
        rd_full(v);
        exp = (c0 + ((m + 1) * nums[i]) / dens[i]) & CMASK;
        chk($sformatf("R2 rate %0d/%0d window %0d", nums[i], dens[i], m + 1), v, exp);
        rd(8'h10, v);
        chk("R3 numerator word readback", v, longint'({20'hA5C3E, 12'(nums[i])}));
        rd(8'h14, v);
        chk("R3 denominator word readback", v, longint'({20'h5A3C1, 12'(dens[i])}));
      end
    end

    // R6: low read just below a half boundary, high read after the crossing
    wr(8'h14, 32'd0);
    rd_full(c0);
    wr(8'h10, 32'd1); wr(8'h14, 32'd1);
    m = (1022 - (c0 & LMASK) + 1024) % 1024;
    idle(int'(m));
    rd(8'h00, lo); chk("R6 low half at boundary", lo, 1023);
    rd(8'h04, hi); chk("R6 captured high half", hi, ((c0 + m + 1) & CMASK) >> HW);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule